// File: doc/BRIEF.md
# Integer and Paired Floating-Point Register File

This block is the architectural register storage of a load-store processor core. It has two banks of 32-bit registers. The integer bank has two read ports and one write port, and its register zero is a constant zero. The floating-point bank also has two read ports and one write port, but each of its ports is given a width mode for every access. In single mode a port reaches one 32-bit register. In double mode it reaches an even/odd register pair, which it treats as one 64-bit value, and the even register holds the upper word.

Writes take effect on the rising clock edge. Reads are combinational from the stored state. There is no forwarding inside the block, so a read of a register in the same cycle that register is written returns the value from before the write. If a double-mode access names an odd register, the block flags it. Such a read returns zero, and such a write leaves the bank unchanged. A synchronous reset clears both banks.

Top module: `regbank_dual`

## Requirements
- R1: While `rst` is high at a rising edge, every register of both banks is cleared, so every read port returns zero after the edge.
- R2: Integer register 0 always reads as zero, and a write addressed to it has no effect.
- R3: An integer write with `iw_en` high stores `iw_data` into register `iw_sel` at the rising edge. Both integer read ports see the new value from the next cycle on.
- R4: A read of a register in the same cycle that register is written returns the value held before the edge, on both banks and every port.
- R5: A floating-point read port in single mode (`*_dbl` = 0) returns register `sel` on bits [31:0] and zero on bits [63:32].
- R6: A single-mode floating-point write stores `fw_data[31:0]` into register `fw_sel` only, and every other register keeps its value.
- R7: A double-mode read with an even `sel` returns register `sel` on bits [63:32] and register `sel+1` on bits [31:0].
- R8: A double-mode write with an even `fw_sel` updates both registers of the pair at the same edge: `fw_data[63:32]` goes into `fw_sel` and `fw_data[31:0]` goes into `fw_sel+1`.
- R9: A double-mode read with an odd `sel` raises that port's illegal flag (`fra_bad` or `frb_bad`) and returns zero data.
- R10: A double-mode write with an odd `fw_sel` raises `fw_bad` and changes no register.
- R11: Every illegal flag is low whenever its port is in single mode or names an even register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ira_sel | input | 5 | Integer read port A register number |
| ira_data | output | 32 | Integer read port A data |
| irb_sel | input | 5 | Integer read port B register number |
| irb_data | output | 32 | Integer read port B data |
| iw_en | input | 1 | Integer write enable |
| iw_sel | input | 5 | Integer write register number |
| iw_data | input | 32 | Integer write data |
| fra_sel | input | 5 | FP read port A register number |
| fra_dbl | input | 1 | FP read port A double mode |
| fra_data | output | 64 | FP read port A data |
| fra_bad | output | 1 | FP read port A odd pair number in double mode |
| frb_sel | input | 5 | FP read port B register number |
| frb_dbl | input | 1 | FP read port B double mode |
| frb_data | output | 64 | FP read port B data |
| frb_bad | output | 1 | FP read port B odd pair number in double mode |
| fw_en | input | 1 | FP write enable |
| fw_sel | input | 5 | FP write register number |
| fw_dbl | input | 1 | FP write double mode |
| fw_data | input | 64 | FP write data; bits [31:0] only in single mode |
| fw_bad | output | 1 | FP write odd pair number in double mode |

## Verification
The bench builds the block with its default parameters: 32 registers in each bank, 32 bits per register. With these values the random register numbers reach the top pair F30/F31. They also collide often enough to produce same-cycle read/write cases and writes to register zero. Random modes on all three floating-point ports mix single and double accesses to the same registers. This shows that a double write and the single reads of its two halves agree, and that an odd-numbered double write leaves both neighbouring registers unchanged.

// File: rtl/regbank_dual.sv
module regbank_dual #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int DW = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ira_sel,
  output logic [XLEN-1:0] ira_data,
  input  logic [AW-1:0]   irb_sel,
  output logic [XLEN-1:0] irb_data,
  input  logic            iw_en,
  input  logic [AW-1:0]   iw_sel,
  input  logic [XLEN-1:0] iw_data,
  input  logic [AW-1:0]   fra_sel,
  input  logic            fra_dbl,
  output logic [DW-1:0]   fra_data,
  output logic            fra_bad,
  input  logic [AW-1:0]   frb_sel,
  input  logic            frb_dbl,
  output logic [DW-1:0]   frb_data,
  output logic            frb_bad,
  input  logic            fw_en,
  input  logic [AW-1:0]   fw_sel,
  input  logic            fw_dbl,
  input  logic [DW-1:0]   fw_data,
  output logic            fw_bad
);

  logic [XLEN-1:0] gpr [NREG];
  logic [XLEN-1:0] fpr [NREG];

  assign fra_bad = fra_dbl & fra_sel[0];
  assign frb_bad = frb_dbl & frb_sel[0];
  assign fw_bad  = fw_dbl & fw_sel[0];

  assign ira_data = (ira_sel == '0) ? '0 : gpr[ira_sel];
  assign irb_data = (irb_sel == '0) ? '0 : gpr[irb_sel];

  function automatic logic [DW-1:0] fp_read(input logic [AW-1:0] sel, input logic dbl);
    if (!dbl)
      return {{XLEN{1'b0}}, fpr[sel]};
    else if (sel[0])
      return '0;
    else
      return {fpr[sel], fpr[{sel[AW-1:1], 1'b1}]};
  endfunction

  assign fra_data = fp_read(fra_sel, fra_dbl);
  assign frb_data = fp_read(frb_sel, frb_dbl);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else if (iw_en && iw_sel != '0) begin
      gpr[iw_sel] <= iw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) fpr[i] <= '0;
    end else if (fw_en && !fw_bad) begin
      if (fw_dbl) begin
        fpr[fw_sel]                   <= fw_data[DW-1:XLEN];
        fpr[{fw_sel[AW-1:1], 1'b1}]   <= fw_data[XLEN-1:0];
      end else begin
        fpr[fw_sel] <= fw_data[XLEN-1:0];
      end
    end
  end

endmodule

// File: rtl/regbank_dual_chk.sv
module regbank_dual_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int DW = 2 * XLEN
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   ira_sel,
  input logic [XLEN-1:0] ira_data,
  input logic [AW-1:0]   irb_sel,
  input logic [XLEN-1:0] irb_data,
  input logic            iw_en,
  input logic [AW-1:0]   iw_sel,
  input logic [XLEN-1:0] iw_data,
  input logic [AW-1:0]   fra_sel,
  input logic            fra_dbl,
  input logic [DW-1:0]   fra_data,
  input logic            fra_bad,
  input logic [AW-1:0]   frb_sel,
  input logic            frb_dbl,
  input logic [DW-1:0]   frb_data,
  input logic            frb_bad,
  input logic            fw_en,
  input logic [AW-1:0]   fw_sel,
  input logic            fw_dbl,
  input logic [DW-1:0]   fw_data,
  input logic            fw_bad
);

  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> ira_data == '0 && irb_data == '0 && fra_data == '0 && frb_data == '0);

  p_zero_reg_r2: assert property (@(posedge clk) disable iff (rst)
    ira_sel == '0 |-> ira_data == '0);

  p_int_write_r3: assert property (@(posedge clk) disable iff (rst)
    iw_en && iw_sel != '0 |=> (ira_sel != $past(iw_sel) || ira_data == $past(iw_data)));

  p_single_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !fra_dbl |-> fra_data[DW-1:XLEN] == '0);

  p_pair_write_r8: assert property (@(posedge clk) disable iff (rst)
    fw_en && fw_dbl && !fw_sel[0] |=>
      (!frb_dbl || frb_sel != $past(fw_sel) || frb_data == $past(fw_data)));

  p_odd_read_r9: assert property (@(posedge clk) disable iff (rst)
    fra_bad |-> fra_data == '0 && fra_dbl);

  p_odd_write_held_r10: assert property (@(posedge clk) disable iff (rst)
    fw_en && fw_bad && !fra_dbl && fra_sel == fw_sel |=>
      (!$stable(fra_sel) || !$stable(fra_dbl) || $stable(fra_data)));

  p_flag_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !frb_dbl || !frb_sel[0] |-> !frb_bad);

endmodule

bind regbank_dual regbank_dual_chk #(.XLEN(XLEN), .NREG(NREG)) chk (.*);

// File: tb/regbank_dual_test.sv
module regbank_dual_test;
  logic clk = 0, rst = 1;
  logic [4:0]  ira_sel = 0, irb_sel = 0, iw_sel = 0, fra_sel = 0, frb_sel = 0, fw_sel = 0;
  logic [31:0] ira_data, irb_data, iw_data = 0;
  logic [63:0] fra_data, frb_data, fw_data = 0;
  logic iw_en = 0, fra_dbl = 0, frb_dbl = 0, fw_en = 0, fw_dbl = 0;
  logic fra_bad, frb_bad, fw_bad;

  regbank_dual uut (.*);

  always #10 clk = ~clk;

  logic [31:0] ri [32];
  logic [31:0] rf [32];
  string ti [32];
  string tf [32];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] fexp(logic [4:0] s, logic d);
    if (!d) return {32'h0, rf[s]};
    if (s[0]) return 64'h0;
    return {rf[s], rf[s | 5'd1]};
  endfunction

  function automatic string ftag(logic [4:0] s, logic d);
    if (fw_en && (fw_sel == s || (fw_dbl && (fw_sel | 5'd1) == (s | 5'd1)))) return "R4";
    if (!d) return (tf[s] == "") ? "R5" : tf[s];
    if (s[0]) return "R9";
    return (tf[s] == "R1") ? "R1" : "R7";
  endfunction

  task automatic compare();
    string t;
    t = (ira_sel == 0) ? "R2" : (iw_en && iw_sel == ira_sel) ? "R4" : ti[ira_sel];
    check(t, {32'h0, ira_data}, {32'h0, (ira_sel == 0) ? 32'h0 : ri[ira_sel]});
    t = (irb_sel == 0) ? "R2" : (iw_en && iw_sel == irb_sel) ? "R4" : ti[irb_sel];
    check(t, {32'h0, irb_data}, {32'h0, (irb_sel == 0) ? 32'h0 : ri[irb_sel]});
    check(ftag(fra_sel, fra_dbl), fra_data, fexp(fra_sel, fra_dbl));
    check(ftag(frb_sel, frb_dbl), frb_data, fexp(frb_sel, frb_dbl));
    check((fra_dbl && fra_sel[0]) ? "R9" : "R11", {63'h0, fra_bad}, {63'h0, fra_dbl & fra_sel[0]});
    check((frb_dbl && frb_sel[0]) ? "R9" : "R11", {63'h0, frb_bad}, {63'h0, frb_dbl & frb_sel[0]});
    check((fw_dbl && fw_sel[0]) ? "R10" : "R11", {63'h0, fw_bad}, {63'h0, fw_dbl & fw_sel[0]});
  endtask

  task automatic update();
    if (rst) begin
      for (int i = 0; i < 32; i++) begin ri[i] = 0; rf[i] = 0; ti[i] = "R1"; tf[i] = "R1"; end
      return;
    end
    if (iw_en) begin
      if (iw_sel == 0) ti[0] = "R2";
      else begin ri[iw_sel] = iw_data; ti[iw_sel] = "R3"; end
    end
    if (fw_en) begin
      if (!fw_dbl) begin rf[fw_sel] = fw_data[31:0]; tf[fw_sel] = "R6"; end
      else if (fw_sel[0]) begin tf[fw_sel] = "R10"; tf[fw_sel & 5'h1e] = "R10"; end
      else begin
        rf[fw_sel] = fw_data[63:32]; rf[fw_sel | 5'd1] = fw_data[31:0];
        tf[fw_sel] = "R8"; tf[fw_sel | 5'd1] = "R8";
      end
    end
  endtask

  task automatic cycle();
    #5 compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin ri[i] = 'x; rf[i] = 'x; ti[i] = "R1"; tf[i] = "R1"; end
    @(negedge clk);
    @(posedge clk); update();
    @(negedge clk);
    cycle();
    rst = 0;
    iw_en = 1; iw_sel = 0; iw_data = 32'hdead_beef; cycle();
    iw_sel = 5; iw_data = 32'h1234_5678; ira_sel = 5; cycle();
    iw_en = 0; cycle();
    fw_en = 1; fw_dbl = 1; fw_sel = 6; fw_data = 64'haaaa_0001_bbbb_0002;
    fra_sel = 6; fra_dbl = 1; frb_sel = 7; cycle();
    fw_sel = 7; fw_data = 64'hffff_ffff_ffff_ffff; cycle();
    fw_en = 0; frb_sel = 6; cycle();
    fra_dbl = 0; fra_sel = 31; fw_en = 1; fw_dbl = 0; fw_sel = 31; fw_data = 64'h5555_0000_c0de_f00d; cycle();
    fw_en = 0; cycle();
    for (int n = 0; n < 4000; n++) begin
      iw_en = $urandom_range(0, 1); iw_sel = 5'($urandom); iw_data = $urandom;
      ira_sel = 5'($urandom); irb_sel = $urandom_range(0, 3) == 0 ? iw_sel : 5'($urandom);
      fw_en = $urandom_range(0, 1); fw_dbl = $urandom_range(0, 1); fw_sel = 5'($urandom);
      fw_data = {$urandom, $urandom};
      fra_sel = 5'($urandom); fra_dbl = $urandom_range(0, 1);
      frb_sel = $urandom_range(0, 2) == 0 ? fw_sel : 5'($urandom); frb_dbl = $urandom_range(0, 1);
      rst = (n == 2000);
      cycle();
    end
    rst = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule